// File: doc/BRIEF.md
# Gated Countdown Timer Channel with Control Port

This block is one countdown channel of a PC-style interval timer, together with the system control port that gates it and reports its output. Software reaches it through a byte-wide write bus and a combinational read bus. The bus decodes three addresses: a command register, a channel data register and the control port.

To time an interval, software first sets the gate bit in the control port. It then writes the command byte that selects this channel. After that it writes a 16-bit count as two data bytes, low byte first. The channel then decrements once per gated tick of a clock-enable input that is synchronous to the bus clock. When the count reaches zero, the channel raises its output.

Software polls bit 5 of the control port until it reads 1, counting its loop passes. With the low 16-bit count the block suits processor clock calibration: 35,795 ticks is about 30 ms at a 1,193,182 Hz tick rate. The output can also be routed to a speaker pin under a port enable bit.

Top module: `itc_top`

## Requirements
- R1: After reset the control port reads 0x00, the speaker output is 0 and the channel output is low.
- R2: A write to the command address (2) whose bits 7:6 are 10 forces the channel output low and stops counting until a new count is loaded. A command byte with any other value in bits 7:6 is ignored.
- R3: Data writes (address 1) made before any accepted command byte are ignored and start no count.
- R4: After a command byte, a low-byte write and then a high-byte write to address 1 load the count. Each later tick with the gate set decrements it, and the output goes high on exactly the Nth such tick for a loaded count N.
- R5: Ticks that arrive while the gate bit (control port bit 0) is 0 do not change the count.
- R6: Once high, the output stays high while further ticks arrive (the counter wraps through 0xFFFF), until a command byte or data byte is written.
- R7: A low-byte write during counting stops the count and drives the output low. The new count takes effect only after its high byte is written, and counts from that value.
- R8: A control port read (address 0) returns the level of the channel output in bit 5 and the last written bits 3:0 in bits 3:0. All other bits read 0.
- R9: The speaker output equals the channel output while control port bit 1 is set, and is 0 otherwise.
- R10: Reads of the command address, the data address or the unused address 3 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register address: 0 port, 1 data, 2 command |
| busWr | input | 1 | Write strobe, one cycle per byte |
| busWrData | input | 8 | Write data byte |
| busRdData | output | 8 | Combinational read data for busAddr |
| tickEn | input | 1 | Counter tick enable, one clock cycle per tick |
| speakerOut | output | 1 | Channel output routed to the speaker |

## Verification
A bus write to the channel and a counter tick can arrive in the same clock cycle. The design gives the write precedence, so a command byte or count byte written in that cycle cancels the tick. The bench provokes this by reloading a count part way through a run while ticks keep arriving. It judges the result by the number of polled ticks until bit 5 rises, which must equal the new count exactly. The checker also watches that the output never rises except with the counter at zero, and that it stays high until a register write clears it.

// File: rtl/itc_pkg.sv
package itc_pkg;
  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_WAIT_LO = 2'd1,
    LD_WAIT_HI = 2'd2,
    LD_RUN = 2'd3
  } loadState_t;

  typedef struct packed {
    logic clearOut;
    logic latchLo;
    logic loadCnt;
    logic countEn;
  } ctlStrobe_t;
endpackage

// File: rtl/itc_ctrl.sv
module itc_ctrl
  import itc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter int PORT_ADDR = 0,
  parameter int DATA_ADDR = 1,
  parameter int CMD_ADDR = 2,
  parameter int CH_SEL = 2,
  parameter int PORT_KEEP = 4,
  parameter int OUT_BIT = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              tickEn,
  input  logic              chanOut,
  output ctlStrobe_t        strobe,
  output logic [DATA_W-1:0] busRdData,
  output logic              gateOn,
  output logic              spkEn
);
  loadState_t state, stateNext;
  logic [PORT_KEEP-1:0] portReg;
  logic cmdHit, dataWr, portWr;

  assign cmdHit = busWr && (busAddr == ADDR_W'(CMD_ADDR)) && (busWrData[DATA_W-1 -: 2] == 2'(CH_SEL));
  assign dataWr = busWr && (busAddr == ADDR_W'(DATA_ADDR));
  assign portWr = busWr && (busAddr == ADDR_W'(PORT_ADDR));
  assign gateOn = portReg[0];
  assign spkEn = portReg[1];

  always_comb begin
    strobe = '0;
    stateNext = state;
    if (cmdHit) begin
      strobe.clearOut = 1'b1;
      stateNext = LD_WAIT_LO;
    end else if (dataWr) begin
      case (state)
        LD_WAIT_LO, LD_RUN: begin
          strobe.latchLo = 1'b1;
          strobe.clearOut = 1'b1;
          stateNext = LD_WAIT_HI;
        end
        LD_WAIT_HI: begin
          strobe.loadCnt = 1'b1;
          stateNext = LD_RUN;
        end
        default: stateNext = state;
      endcase
    end else begin
      strobe.countEn = (state == LD_RUN) && tickEn && gateOn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= LD_IDLE;
      portReg <= '0;
    end else begin
      state <= stateNext;
      if (portWr) portReg <= busWrData[PORT_KEEP-1:0];
    end
  end

  always_comb begin
    busRdData = '0;
    if (busAddr == ADDR_W'(PORT_ADDR)) begin
      busRdData[PORT_KEEP-1:0] = portReg;
      busRdData[OUT_BIT] = chanOut;
    end
  end
endmodule

// File: rtl/itc_datapath.sv
module itc_datapath
  import itc_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [DATA_W-1:0] busWrData,
  output logic [CNT_W-1:0]  count,
  output logic              chanOut
);
  logic [DATA_W-1:0] loLatch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loLatch <= '0;
      count <= '0;
      chanOut <= 1'b0;
    end else begin
      if (strobe.latchLo) loLatch <= busWrData;
      if (strobe.loadCnt) count <= {busWrData, loLatch};
      else if (strobe.countEn) count <= count - CNT_W'(1);
      if (strobe.clearOut || strobe.loadCnt) chanOut <= 1'b0;
      else if (strobe.countEn && count == CNT_W'(1)) chanOut <= 1'b1;
    end
  end
endmodule

// File: rtl/itc_top.sv
module itc_top
  import itc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter int PORT_ADDR = 0,
  parameter int DATA_ADDR = 1,
  parameter int CMD_ADDR = 2,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              tickEn,
  output logic              speakerOut
);
  ctlStrobe_t strobe;
  logic gateOn, spkEn, chanOut;
  logic [CNT_W-1:0] count;

  itc_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR),
    .DATA_ADDR(DATA_ADDR), .CMD_ADDR(CMD_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWrData(busWrData), .tickEn(tickEn), .chanOut(chanOut),
    .strobe(strobe), .busRdData(busRdData), .gateOn(gateOn), .spkEn(spkEn)
  );

  itc_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWrData(busWrData),
    .count(count), .chanOut(chanOut)
  );

  assign speakerOut = chanOut & spkEn;
endmodule

// File: rtl/itc_chk.sv
module itc_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter int DATA_ADDR = 1,
  parameter int CMD_ADDR = 2,
  localparam int CNT_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic [DATA_W-1:0] busWrData,
  input logic              gateOn,
  input logic              chanOut,
  input logic [CNT_W-1:0]  count
);
  logic regWr;
  assign regWr = busWr && (busAddr == ADDR_W'(CMD_ADDR) || busAddr == ADDR_W'(DATA_ADDR));

  // R2
  cmd_clears_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_W'(CMD_ADDR) && busWrData[DATA_W-1 -: 2] == 2'b10) |=> !chanOut);

  // R5
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!gateOn && !(busWr && busAddr == ADDR_W'(DATA_ADDR))) |=> $stable(count));

  // R4
  rise_at_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chanOut) |-> (count == '0));

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chanOut && !regWr) |=> chanOut);
endmodule

bind itc_top itc_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .CMD_ADDR(CMD_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
  .busWrData(busWrData), .gateOn(gateOn), .chanOut(chanOut), .count(count)
);

// File: tb/tb_itc_top.sv
`timescale 1ns/1ps
module tb_itc_top;
  localparam int PORT_A = 0;
  localparam int DATA_A = 1;
  localparam int CMD_A = 2;

  typedef struct {
    string req;
    logic [7:0] exp;
    bit isSpk;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic busWr = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic tickEn = 1'b0;
  logic speakerOut;
  logic sampleReq = 1'b0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  expItem_t sbQ[$];

  always #2 clk = ~clk;

  itc_top dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWrData(busWrData), .busRdData(busRdData), .tickEn(tickEn),
    .speakerOut(speakerOut)
  );

  task automatic note(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected items and compares at the falling edge
  always @(negedge clk) begin
    if (sampleReq && sbQ.size() > 0) begin
      expItem_t it;
      logic [7:0] act;
      it = sbQ.pop_front();
      act = it.isSpk ? {7'b0, speakerOut} : busRdData;
      note(act == it.exp, it.req, act, it.exp);
    end
  end

  task automatic wr(int a, logic [7:0] d);
    @(posedge clk); #1;
    busAddr = 2'(a); busWrData = d; busWr = 1'b1;
    @(posedge clk); #1;
    busWr = 1'b0;
  endtask

  task automatic expectRd(int a, logic [7:0] e, string req, bit spk = 1'b0);
    expItem_t it;
    @(posedge clk); #1;
    busAddr = 2'(a);
    it.req = req; it.exp = e; it.isSpk = spk;
    sbQ.push_back(it);
    sampleReq = 1'b1;
    @(posedge clk); #1;
    sampleReq = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; tickEn = 1'b1;
      @(posedge clk); #1; tickEn = 1'b0;
    end
  endtask

  task automatic pollCount(output int n);
    bit hi;
    n = 0; hi = 1'b0;
    busAddr = 2'(PORT_A);
    while (!hi && n < 2000) begin
      ticks(1);
      n++;
      @(negedge clk);
      hi = busRdData[5];
    end
  endtask

  task automatic load(logic [15:0] c);
    wr(CMD_A, 8'hB0);
    wr(DATA_A, c[7:0]);
    wr(DATA_A, c[15:8]);
  endtask

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    expectRd(PORT_A, 8'h00, "R1 port");
    expectRd(PORT_A, 8'h00, "R1 speaker", 1'b1);
    // R10 other addresses read zero
    expectRd(CMD_A, 8'h00, "R10 cmd");

    // R3 data before any command is ignored
    wr(PORT_A, 8'h01);
    wr(DATA_A, 8'h02);
    wr(DATA_A, 8'h00);
    ticks(10);
    expectRd(PORT_A, 8'h01, "R3 no count");

    // R4 exact count
    load(16'd5);
    pollCount(n);
    note(n == 5, "R4 ticks to output", n, 5);
    expectRd(PORT_A, 8'h21, "R8 output bit");

    // R6 stays high through further ticks (wrap)
    ticks(3);
    expectRd(PORT_A, 8'h21, "R6 hold");

    // R2 other channel ignored
    wr(CMD_A, 8'h30);
    expectRd(PORT_A, 8'h21, "R2 other channel");

    // R9 speaker routing
    wr(PORT_A, 8'h03);
    expectRd(PORT_A, 8'h01, "R9 speaker on", 1'b1);
    wr(PORT_A, 8'h01);
    expectRd(PORT_A, 8'h00, "R9 speaker off", 1'b1);

    // R2 accepted command clears output
    wr(CMD_A, 8'hB0);
    expectRd(PORT_A, 8'h01, "R2 clear");

    // R5 gate low holds the count
    wr(DATA_A, 8'h04);
    wr(DATA_A, 8'h00);
    wr(PORT_A, 8'h00);
    ticks(10);
    expectRd(PORT_A, 8'h00, "R5 gated off");
    wr(PORT_A, 8'h01);
    pollCount(n);
    note(n == 4, "R5 ticks after gate", n, 4);

    // R7 reload while counting, with ticks alongside writes
    load(16'd10);
    ticks(3);
    fork
      ticks(2);
      wr(DATA_A, 8'h02);
    join
    ticks(5);
    expectRd(PORT_A, 8'h01, "R7 halted");
    fork
      ticks(1);
      wr(DATA_A, 8'h00);
    join
    pollCount(n);
    note(n == 2, "R7 new count", n, 2);

    // R6 data write clears a high output
    wr(DATA_A, 8'h07);
    expectRd(PORT_A, 8'h01, "R6 cleared by write");

    // R8 port bit storage
    load(16'd1);
    pollCount(n);
    note(n == 1, "R4 count of one", n, 1);
    wr(PORT_A, 8'hFF);
    expectRd(PORT_A, 8'h2F, "R8 port bits");
    expectRd(PORT_A, 8'h01, "R9 speaker high", 1'b1);

    // R10 data and unused address
    expectRd(DATA_A, 8'h00, "R10 data");
    expectRd(3, 8'h00, "R10 unused");

    repeat (4) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule